// File: doc/BRIEF.md
# Power-On Admission Gate for a Four-Channel PoE Controller

This block decides whether a channel of a four-channel power-sourcing controller may be switched on. The channels form two pairs (channels 0/1 and channels 2/3). One configuration byte holds a 3-bit budget code for each pair. When a channel asks to power on, the block checks the measured device class against the budget that applies to that channel. It then either raises a grant level or sets a sticky insufficient-power fault.

A channel can also be armed ahead of time. This models automatic operation, where detection and classification are enabled before power-on. Arming freezes the pair code into the channel at that moment. A later power-on request is then judged against the frozen code, whatever the register holds by then.

Each channel runs a three-state machine with the states IDLE, ARMED and POWERED:
- IDLE to ARMED on an arm pulse.
- IDLE or ARMED to POWERED on a power-on request that passes the budget check.
- IDLE or ARMED to IDLE on a power-on request that fails the check. The fault is raised.
- ARMED or POWERED to IDLE on a power-off request.
- POWERED to POWERED while no power-off request arrives.

Top module: `poe_alloc_gate`

## Requirements
- R1: After reset the configuration byte reads 0x00 and every grant and fault output is 0.
- R2: A cycle with `cfg_wr_en` high stores all 8 bits of `cfg_wr_data`. From the next cycle `cfg_rd_data` returns them. Bits 2:0 are the code for channels 0 and 1, and bits 6:4 are the code for channels 2 and 3. Bits 7 and 3 are stored but unused.
- R3: Code 000 (15.4 W) admits classes 0 to 3 and rejects class 4. Any `ch_class` value of 4 or more counts as class 4.
- R4: Code 001 (4 W) admits only class 1.
- R5: Code 010 (7 W) admits only classes 1 and 2.
- R6: Code 011 (30 W) admits classes 0 to 4.
- R7: A code with bit 2 set (1xx) admits no class.
- R8: Both channels of a pair follow the pair's code. The two pairs are judged independently.
- R9: An admitted power-on request raises `grant` for that channel one cycle later. `grant` stays high until a power-off request, and falls in the cycle after that request.
- R10: A rejected power-on request sets the channel's `flt_insuff` one cycle later. The fault stays set until a `flt_clr` pulse. If a rejection and a clear arrive in the same cycle, the fault stays set.
- R11: An arm pulse on an idle channel captures the pair code. A later power-on request is judged against the captured code, and register writes made in between do not affect it. A power-off request returns an armed channel to IDLE, after which it uses the live code again.
- R12: While a channel is powered, further power-on requests and register writes leave its grant high and its fault clear.
- R13: A power-off request wins over a power-on request in the same cycle. The channel ends with `grant` low and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_data | input | 8 | Configuration byte write value |
| cfg_rd_data | output | 8 | Configuration byte read value |
| pwr_on_req | input | 4 | Per-channel power-on request pulse |
| pwr_off_req | input | 4 | Per-channel power-off request pulse |
| arm_req | input | 4 | Per-channel arm pulse that captures the pair code |
| flt_clr | input | 4 | Per-channel fault clear pulse |
| ch_class | input | 12 | Measured class per channel, 3 bits each, channel 0 in bits 2:0 |
| grant | output | 4 | Per-channel power grant level |
| flt_insuff | output | 4 | Per-channel sticky insufficient-power fault |

## Verification
The hardest case to reach from the ports is a decision that uses a frozen code which no longer matches the register. To reach it, the stimulus arms a channel under one pair code, then rewrites the register to a code that gives the opposite verdict, and only then issues the power-on request. This is done in both directions: arming under 4 W and then writing 30 W must still reject a class 3 device, and arming under 30 W and then writing 4 W must still admit it. The same-cycle collisions are also driven at the ports: power-off together with power-on, and fault clear together with a new rejection.

// File: rtl/poe_alloc_pkg.sv
package poe_alloc_pkg;
    localparam int CODE_W  = 3;
    localparam int CLASS_W = 3;
    localparam int FIELD_W = CODE_W + 1;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_ARMED   = 2'd1,
        CH_POWERED = 2'd2
    } ch_state_e;

    localparam logic [CODE_W-1:0] BUDGET_15W4 = 3'b000;
    localparam logic [CODE_W-1:0] BUDGET_4W   = 3'b001;
    localparam logic [CODE_W-1:0] BUDGET_7W   = 3'b010;
    localparam logic [CODE_W-1:0] BUDGET_30W  = 3'b011;
endpackage

// File: rtl/poe_alloc_cfg.sv
module poe_alloc_cfg
    import poe_alloc_pkg::*;
#(
    parameter int NUM_PAIR = 2,
    localparam int REG_W   = NUM_PAIR * FIELD_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [REG_W-1:0]           wr_data,
    output logic [REG_W-1:0]           rd_data,
    output logic [NUM_PAIR*CODE_W-1:0] pair_code
);
    logic [REG_W-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_en)
            cfg_q <= wr_data;
    end

    assign rd_data = cfg_q;

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_field
        assign pair_code[p*CODE_W +: CODE_W] = cfg_q[p*FIELD_W +: CODE_W];
    end
endmodule

// File: rtl/poe_alloc_rule.sv
module poe_alloc_rule
    import poe_alloc_pkg::*;
(
    input  logic [CODE_W-1:0]  code,
    input  logic [CLASS_W-1:0] pd_class,
    output logic               admit
);
    localparam logic [CLASS_W-1:0] TOP_CLASS = CLASS_W'(4);

    logic [CLASS_W-1:0] cls_sat;

    always_comb begin
        cls_sat = (pd_class > TOP_CLASS) ? TOP_CLASS : pd_class;
        unique case (code)
            BUDGET_15W4: admit = (cls_sat < TOP_CLASS);
            BUDGET_4W:   admit = (cls_sat == CLASS_W'(1));
            BUDGET_7W:   admit = (cls_sat == CLASS_W'(1)) || (cls_sat == CLASS_W'(2));
            BUDGET_30W:  admit = 1'b1;
            default:     admit = 1'b0;
        endcase
    end
endmodule

// File: rtl/poe_alloc_chan.sv
module poe_alloc_chan
    import poe_alloc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               on_req,
    input  logic               off_req,
    input  logic               arm_req,
    input  logic               clr_req,
    input  logic [CODE_W-1:0]  live_code,
    input  logic [CLASS_W-1:0] pd_class,
    output logic               grant,
    output logic               fault
);
    ch_state_e         state_q, state_d;
    logic [CODE_W-1:0] held_q;
    logic [CODE_W-1:0] use_code;
    logic              admit;
    logic              reject;
    logic              capture;

    assign use_code = (state_q == CH_ARMED) ? held_q : live_code;

    poe_alloc_rule u_rule (
        .code     (use_code),
        .pd_class (pd_class),
        .admit    (admit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (off_req)      state_d = CH_IDLE;
                else if (on_req)  state_d = admit ? CH_POWERED : CH_IDLE;
                else if (arm_req) state_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (off_req)      state_d = CH_IDLE;
                else if (on_req)  state_d = admit ? CH_POWERED : CH_IDLE;
            end
            CH_POWERED: begin
                if (off_req)      state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CH_IDLE;
        else
            state_q <= state_d;
    end

    assign reject  = on_req && !off_req && (state_q != CH_POWERED) && !admit;
    assign capture = (state_q == CH_IDLE) && !off_req && (on_req || arm_req);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
            fault  <= 1'b0;
        end else begin
            if (capture)
                held_q <= live_code;
            if (reject)
                fault <= 1'b1;
            else if (clr_req)
                fault <= 1'b0;
        end
    end

    always_comb begin
        grant = (state_q == CH_POWERED);
    end
endmodule

// File: rtl/poe_alloc_gate.sv
module poe_alloc_gate
    import poe_alloc_pkg::*;
#(
    parameter int NUM_CH    = 4,
    localparam int NUM_PAIR = NUM_CH / 2,
    localparam int REG_W    = NUM_PAIR * FIELD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr_en,
    input  logic [REG_W-1:0]          cfg_wr_data,
    output logic [REG_W-1:0]          cfg_rd_data,
    input  logic [NUM_CH-1:0]         pwr_on_req,
    input  logic [NUM_CH-1:0]         pwr_off_req,
    input  logic [NUM_CH-1:0]         arm_req,
    input  logic [NUM_CH-1:0]         flt_clr,
    input  logic [NUM_CH*CLASS_W-1:0] ch_class,
    output logic [NUM_CH-1:0]         grant,
    output logic [NUM_CH-1:0]         flt_insuff
);
    logic [NUM_PAIR*CODE_W-1:0] pair_code;

    poe_alloc_cfg #(.NUM_PAIR(NUM_PAIR)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_data   (cfg_wr_data),
        .rd_data   (cfg_rd_data),
        .pair_code (pair_code)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        poe_alloc_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .on_req    (pwr_on_req[c]),
            .off_req   (pwr_off_req[c]),
            .arm_req   (arm_req[c]),
            .clr_req   (flt_clr[c]),
            .live_code (pair_code[(c/2)*CODE_W +: CODE_W]),
            .pd_class  (ch_class[c*CLASS_W +: CLASS_W]),
            .grant     (grant[c]),
            .fault     (flt_insuff[c])
        );
    end
endmodule

// File: rtl/poe_alloc_gate_chk.sv
module poe_alloc_gate_chk #(
    parameter int NUM_CH = 4,
    parameter int REG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [REG_W-1:0]  cfg_wr_data,
    input logic [REG_W-1:0]  cfg_rd_data,
    input logic [NUM_CH-1:0] pwr_on_req,
    input logic [NUM_CH-1:0] pwr_off_req,
    input logic [NUM_CH-1:0] flt_clr,
    input logic [NUM_CH-1:0] grant,
    input logic [NUM_CH-1:0] flt_insuff
);
    AST_CFG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> (cfg_rd_data == $past(cfg_wr_data))); // R2
    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> $stable(cfg_rd_data)); // R2

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grant[c]) |-> ($past(pwr_on_req[c]) && !$past(pwr_off_req[c]))); // R9
        AST_GRANT_DROPS_ON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(grant[c]) |-> $past(pwr_off_req[c])); // R9
        AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_off_req[c] |=> !grant[c]); // R13
        AST_FAULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flt_insuff[c]) |-> $past(pwr_on_req[c])); // R10
        AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flt_insuff[c]) |-> $past(flt_clr[c])); // R10
        AST_GRANT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grant[c]) |-> !$rose(flt_insuff[c])); // R9
    end
endmodule

bind poe_alloc_gate poe_alloc_gate_chk #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .pwr_on_req  (pwr_on_req),
    .pwr_off_req (pwr_off_req),
    .flt_clr     (flt_clr),
    .grant       (grant),
    .flt_insuff  (flt_insuff)
);

// File: tb/poe_alloc_gate_tb.sv
module poe_alloc_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 25;

    // entry: {code[2:0], class[2:0], expect_admit}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b000_000_1, 7'b000_001_1, 7'b000_010_1, 7'b000_011_1, 7'b000_100_0,
        7'b001_000_0, 7'b001_001_1, 7'b001_010_0, 7'b001_011_0, 7'b001_100_0,
        7'b010_000_0, 7'b010_001_1, 7'b010_010_1, 7'b010_011_0, 7'b010_111_0,
        7'b011_000_1, 7'b011_001_1, 7'b011_010_1, 7'b011_011_1, 7'b011_110_1,
        7'b101_000_0, 7'b100_001_0, 7'b110_010_0, 7'b111_011_0, 7'b101_100_0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_data = '0;
    logic [7:0]  cfg_rd_data;
    logic [3:0]  pwr_on_req = '0;
    logic [3:0]  pwr_off_req = '0;
    logic [3:0]  arm_req = '0;
    logic [3:0]  flt_clr = '0;
    logic [11:0] ch_class = '0;
    logic [3:0]  grant;
    logic [3:0]  flt_insuff;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    poe_alloc_gate u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .pwr_on_req  (pwr_on_req),
        .pwr_off_req (pwr_off_req),
        .arm_req     (arm_req),
        .flt_clr     (flt_clr),
        .ch_class    (ch_class),
        .grant       (grant),
        .flt_insuff  (flt_insuff)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [3:0] on, input logic [3:0] off,
                       input logic [3:0] arm, input logic [3:0] clr);
        pwr_on_req = on; pwr_off_req = off; arm_req = arm; flt_clr = clr;
        @(negedge clk);
        pwr_on_req = '0; pwr_off_req = '0; arm_req = '0; flt_clr = '0;
    endtask

    task automatic wr(input logic [7:0] v);
        cfg_wr_en = 1'b1; cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic set_cls(input int ch, input logic [2:0] v);
        ch_class[ch*3 +: 3] = v;
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cfg", {24'd0, cfg_rd_data}, 32'h00);
        chk("R1 grant", {28'd0, grant}, 32'h0);
        chk("R1 fault", {28'd0, flt_insuff}, 32'h0);

        wr(8'hA5);
        chk("R2 readback", {24'd0, cfg_rd_data}, 32'hA5);
        wr(8'h88);
        chk("R2 reserved bits", {24'd0, cfg_rd_data}, 32'h88);

        for (int i = 0; i < NVEC; i++) begin
            logic [2:0] code;
            logic [2:0] cls;
            logic       ex;
            string      tag;
            {code, cls, ex} = VEC[i];
            case (code)
                3'b000:  tag = "R3";
                3'b001:  tag = "R4";
                3'b010:  tag = "R5";
                3'b011:  tag = "R6";
                default: tag = "R7";
            endcase
            wr({1'b0, code, 1'b0, code});
            set_cls(0, cls);
            cyc(4'b0001, 4'b0000, 4'b0000, 4'b0000);
            chk({tag, " grant"}, {31'd0, grant[0]}, {31'd0, ex});
            chk({tag, " fault"}, {31'd0, flt_insuff[0]}, {31'd0, !ex});
            cyc(4'b0000, 4'b0001, 4'b0000, 4'b0001);
            chk({tag, " cleanup"}, {30'd0, grant[0], flt_insuff[0]}, 32'd0);
        end

        // R8: pair 0/1 at 30 W, pair 2/3 at 4 W, all class 3
        wr(8'h13);
        for (int c = 0; c < 4; c++) set_cls(c, 3'd3);
        cyc(4'b1111, 4'b0000, 4'b0000, 4'b0000);
        chk("R8 grant", {28'd0, grant}, 32'h3);
        chk("R8 fault", {28'd0, flt_insuff}, 32'hC);

        // R12: powered channels ignore requests and writes
        wr(8'h77);
        cyc(4'b0011, 4'b0000, 4'b0000, 4'b0000);
        chk("R12 grant held", {28'd0, grant}, 32'h3);
        chk("R12 no fault", {28'd0, flt_insuff}, 32'hC);

        // R10: clear and new rejection in the same cycle keep the fault
        cyc(4'b0100, 4'b0000, 4'b0000, 4'b0100);
        chk("R10 set wins", {31'd0, flt_insuff[2]}, 32'd1);
        cyc(4'b0000, 4'b0000, 4'b0000, 4'b0000);
        chk("R10 sticky", {28'd0, flt_insuff}, 32'hC);
        cyc(4'b0000, 4'b0000, 4'b0000, 4'b1100);
        chk("R10 cleared", {28'd0, flt_insuff}, 32'h0);

        // R9: grant drops the cycle after power-off
        cyc(4'b0000, 4'b0011, 4'b0000, 4'b0000);
        chk("R9 off", {28'd0, grant}, 32'h0);

        // R11: arm under 4 W, write 30 W, class 3 still rejected
        wr(8'h01);
        cyc(4'b0000, 4'b0000, 4'b0001, 4'b0000);
        wr(8'h03);
        cyc(4'b0001, 4'b0000, 4'b0000, 4'b0000);
        chk("R11 frozen reject", {30'd0, grant[0], flt_insuff[0]}, 32'd1);
        // R11: arm under 30 W, write 4 W, class 3 still admitted
        cyc(4'b0000, 4'b0000, 4'b0010, 4'b0001);
        wr(8'h01);
        cyc(4'b0010, 4'b0000, 4'b0000, 4'b0000);
        chk("R11 frozen admit", {30'd0, grant[1], flt_insuff[1]}, 32'd2);
        cyc(4'b0000, 4'b0010, 4'b0000, 4'b0000);
        // R11: disarm returns to live code
        wr(8'h03);
        cyc(4'b0000, 4'b0000, 4'b0001, 4'b0000);
        cyc(4'b0000, 4'b0001, 4'b0000, 4'b0000);
        wr(8'h01);
        cyc(4'b0001, 4'b0000, 4'b0000, 4'b0000);
        chk("R11 disarm live", {30'd0, grant[0], flt_insuff[0]}, 32'd1);
        cyc(4'b0000, 4'b0000, 4'b0000, 4'b0001);

        // R13: off wins over an admissible on
        wr(8'h33);
        cyc(4'b0001, 4'b0001, 4'b0000, 4'b0000);
        chk("R13 off wins", {30'd0, grant[0], flt_insuff[0]}, 32'd0);

        // R3: class code above 4 counts as class 4
        wr(8'h00);
        set_cls(3, 3'd6);
        cyc(4'b1000, 4'b0000, 4'b0000, 4'b0000);
        chk("R3 saturate", {30'd0, grant[3], flt_insuff[3]}, 32'd1);

        // R1: reset clears everything
        set_cls(2, 3'd1);
        wr(8'h33);
        cyc(4'b0100, 4'b0000, 4'b0000, 4'b0000);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 rereset", {16'd0, cfg_rd_data, grant, flt_insuff}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end
endmodule